// File: doc/BRIEF.md
# Multi-Mode Signed Hardware Divider

A register-mapped signed integer divider for a 32-bit register bus. Software loads a 64-bit numerator and a 64-bit denominator, each as two 32-bit words (low word at the lower index), and picks an operand mode in the control word. The mode decides which operands are sign-extended from their low 32 bits, so one unit serves 32/32, 64/32 and 64/64 division. Any write to the control word or to an operand word starts a new computation. A busy flag stays up until the quotient and remainder registers have been updated.

The datapath is an iterative restoring shift-subtract divider that works on magnitudes and needs one iteration per numerator bit. The signs are applied once the iterations are done. Two cases have fixed results and raise an error flag: division by zero, and the most negative 64-bit value divided by minus one. The latency is fixed and is the same for every mode and every operand value.

The bus request uses a valid/ready handshake. `bus_ready` is held high, so a request presented with `bus_valid` is accepted in the same cycle and is never back-pressured. A write takes effect at the clock edge that accepts it. Read data on `bus_rdata` is combinational from `bus_idx` and is valid in the cycle the read is presented. Reads have no side effects.

Top module: `hdiv_unit`

## Requirements
- R1: After reset every register reads zero. Register word indices are: 0 control, 1/2 numerator low/high, 3/4 denominator low/high, 5/6 quotient low/high, 7/8 remainder low/high. Control bits [1:0] are the mode (read/write), bit 14 is the error flag and bit 15 is the busy flag; both flags are read-only.
- R2: A write to index 0..4 sets busy at the edge that accepts it. Busy then reads 1 for exactly 2*32+2 = 66 cycles after that edge and 0 from the next cycle on, and the result registers are updated at the edge where busy clears.
- R3: Mode 0 sign-extends both numerator and denominator from bit 31, so the high words of both operands have no effect.
- R4: Modes 1 and 3 sign-extend only the denominator from bit 31 and use the full 64-bit numerator.
- R5: Mode 2 uses both operands as full 64-bit two's-complement values.
- R6: When no special case applies, the error bit is cleared, the quotient is truncated toward zero and the remainder has the sign of the numerator (numerator = quotient*denominator + remainder).
- R7: When the extended denominator is zero, the error bit is set, the remainder becomes the extended numerator, and the quotient is 1 if that numerator is negative and 0 otherwise.
- R8: When the extended numerator is -2^63 and the extended denominator is -1, the error bit is set, the quotient becomes -2^63 and the remainder register keeps its previous value.
- R9: While busy, the quotient and remainder registers read their previous values. Writes to indices 5..8 are ignored: they change no register and do not start a computation.
- R10: A write to index 0..4 while a computation runs abandons it. The result reflects the operands and mode after that write, and the 66-cycle latency counts from that write.
- R11: `bus_ready` is always 1. Read data for the presented index is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request present |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_idx` |

## Verification
The bench targets the following corner cases:
- Operand high words that must be ignored in the narrow modes. A wrong sign-extension choice gives a grossly different quotient.
- Mode 0 with -2^31 divided by -1. This must yield +2^31 and not the 64-bit overflow case.
- Overflow reached both in mode 3 (through the extended denominator) and in mode 2. The previous remainder must survive, so a design that writes the remainder shows a changed value.
- Division by zero with negative and with positive numerators, including a mode 0 denominator whose low word alone is zero.
- Mixed-sign truncation.
- A restart in mid-computation and writes to the result indices. A design that let a stale computation finish would show a short latency or an old quotient, and one that took result-index writes as starts would raise busy.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  // register word indices on the bus
  localparam int unsigned REG_IDX_W = 4;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL   = 4'd0;
  localparam logic [REG_IDX_W-1:0] IDX_NUM_LO = 4'd1;
  localparam logic [REG_IDX_W-1:0] IDX_DEN_LO = 4'd3;
  localparam logic [REG_IDX_W-1:0] IDX_DEN_HI = 4'd4;
  localparam logic [REG_IDX_W-1:0] IDX_QUO_LO = 4'd5;
  localparam logic [REG_IDX_W-1:0] IDX_REM_LO = 4'd7;

  // control word bit positions (software decodes these)
  localparam int unsigned CTRL_ERR_BIT  = 14;
  localparam int unsigned CTRL_BUSY_BIT = 15;

  typedef enum logic [1:0] {
    MODE_SHORT    = 2'd0,  // both operands from 32 bits
    MODE_WIDE_N   = 2'd1,  // wide numerator, 32-bit denominator
    MODE_FULL     = 2'd2,  // both operands 64 bits
    MODE_WIDE_N_B = 2'd3   // alias of MODE_WIDE_N
  } div_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } core_state_e;
endpackage

// File: rtl/hdiv_prep.sv
module hdiv_prep import hdiv_pkg::*; #(
  parameter int unsigned BUS_W = 32
) (
  input  logic [2*BUS_W-1:0] num_raw,
  input  logic [2*BUS_W-1:0] den_raw,
  input  logic [1:0]         mode,
  output logic [2*BUS_W-1:0] num_ext,
  output logic [2*BUS_W-1:0] num_mag,
  output logic [2*BUS_W-1:0] den_mag,
  output logic               num_neg,
  output logic               den_neg,
  output logic               den_zero,
  output logic               ovf
);
  localparam int unsigned DATA_W = 2 * BUS_W;

  logic [DATA_W-1:0] num_sx, den_sx, den_ext;
  logic              ext_num, ext_den;

  assign num_sx = {{BUS_W{num_raw[BUS_W-1]}}, num_raw[BUS_W-1:0]};
  assign den_sx = {{BUS_W{den_raw[BUS_W-1]}}, den_raw[BUS_W-1:0]};

  always_comb begin
    case (div_mode_e'(mode))
      MODE_SHORT:    begin ext_num = 1'b1; ext_den = 1'b1; end
      MODE_FULL:     begin ext_num = 1'b0; ext_den = 1'b0; end
      default:       begin ext_num = 1'b0; ext_den = 1'b1; end
    endcase
  end

  assign num_ext  = ext_num ? num_sx : num_raw;
  assign den_ext  = ext_den ? den_sx : den_raw;
  assign num_neg  = num_ext[DATA_W-1];
  assign den_neg  = den_ext[DATA_W-1];
  assign num_mag  = num_neg ? (~num_ext + 1'b1) : num_ext;
  assign den_mag  = den_neg ? (~den_ext + 1'b1) : den_ext;
  assign den_zero = (den_ext == '0);
  assign ovf      = (num_ext == {1'b1, {(DATA_W-1){1'b0}}}) && (&den_ext);
endmodule

// File: rtl/hdiv_core.sv
module hdiv_core import hdiv_pkg::*; #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] num_ext,
  input  logic [DATA_W-1:0] num_mag,
  input  logic [DATA_W-1:0] den_mag,
  input  logic              num_neg,
  input  logic              den_neg,
  input  logic              den_zero,
  input  logic              ovf,
  output logic              done,
  output logic [DATA_W-1:0] quo,
  output logic [DATA_W-1:0] rem,
  output logic              err,
  output logic              rem_we
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  core_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] part_q, qbits_q, div_q, nx_q;
  logic              nneg_q, dneg_q, zero_q, ovf_q;

  logic [DATA_W:0]   shifted, diff;
  logic              fits;

  // one restoring step
  assign shifted = {part_q, qbits_q[DATA_W-1]};
  assign diff    = shifted - {1'b0, div_q};
  assign fits    = (shifted >= {1'b0, div_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      part_q  <= '0;
      qbits_q <= '0;
      div_q   <= '0;
      nx_q    <= '0;
      nneg_q  <= 1'b0;
      dneg_q  <= 1'b0;
      zero_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (start) begin
      state_q <= ST_RUN;
      cnt_q   <= CNT_W'(DATA_W);
      part_q  <= '0;
      qbits_q <= num_mag;
      div_q   <= den_mag;
      nx_q    <= num_ext;
      nneg_q  <= num_neg;
      dneg_q  <= den_neg;
      zero_q  <= den_zero;
      ovf_q   <= ovf;
    end else begin
      case (state_q)
        ST_RUN: begin
          part_q  <= fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
          qbits_q <= {qbits_q[DATA_W-2:0], fits};
          cnt_q   <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done = (state_q == ST_FIN) && !start;

  // sign fix-up and special cases
  always_comb begin
    quo    = qbits_q;
    rem    = part_q;
    err    = 1'b0;
    rem_we = 1'b1;
    if (zero_q) begin
      quo = {{(DATA_W-1){1'b0}}, nneg_q};
      rem = nx_q;
      err = 1'b1;
    end else if (ovf_q) begin
      quo    = nx_q;
      err    = 1'b1;
      rem_we = 1'b0;
    end else begin
      if (nneg_q ^ dneg_q) quo = ~qbits_q + 1'b1;
      if (nneg_q)          rem = ~part_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdiv_rdmux.sv
module hdiv_rdmux import hdiv_pkg::*; #(
  parameter int unsigned BUS_W = 32
) (
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [BUS_W-1:0]     ctrl_word,
  input  logic [2*BUS_W-1:0]   num,
  input  logic [2*BUS_W-1:0]   den,
  input  logic [2*BUS_W-1:0]   quo,
  input  logic [2*BUS_W-1:0]   rem,
  output logic [BUS_W-1:0]     rdata
);
  localparam int unsigned WORDS = 2;

  always_comb begin
    rdata = '0;
    if (idx == IDX_CTRL) rdata = ctrl_word;
    for (int k = 0; k < WORDS; k++) begin
      if (idx == REG_IDX_W'(int'(IDX_NUM_LO) + k)) rdata = num[k*BUS_W +: BUS_W];
      if (idx == REG_IDX_W'(int'(IDX_DEN_LO) + k)) rdata = den[k*BUS_W +: BUS_W];
      if (idx == REG_IDX_W'(int'(IDX_QUO_LO) + k)) rdata = quo[k*BUS_W +: BUS_W];
      if (idx == REG_IDX_W'(int'(IDX_REM_LO) + k)) rdata = rem[k*BUS_W +: BUS_W];
    end
  end
endmodule

// File: rtl/hdiv_unit.sv
module hdiv_unit import hdiv_pkg::*; #(
  parameter int unsigned BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_write,
  input  logic [REG_IDX_W-1:0] bus_idx,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata
);
  localparam int unsigned DATA_W = 2 * BUS_W;
  localparam int unsigned WORDS  = DATA_W / BUS_W;

  logic [1:0]        mode_q;
  logic [DATA_W-1:0] num_q, den_q, quo_q, rem_q;
  logic              busy_q, err_q, start_q;
  logic              wr_acc, op_wr, cap;
  logic [BUS_W-1:0]  ctrl_word;

  logic [DATA_W-1:0] p_num_ext, p_num_mag, p_den_mag;
  logic              p_num_neg, p_den_neg, p_den_zero, p_ovf;
  logic              core_done, core_err, core_rem_we;
  logic [DATA_W-1:0] core_quo, core_rem;

  assign bus_ready = 1'b1;
  assign wr_acc    = bus_valid && bus_write;
  assign op_wr     = wr_acc && (bus_idx <= IDX_DEN_HI);
  assign cap       = core_done && !op_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      num_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= op_wr;
      if (op_wr) busy_q <= 1'b1;
      if (wr_acc && bus_idx == IDX_CTRL) mode_q <= bus_wdata[1:0];
      for (int k = 0; k < WORDS; k++) begin
        if (wr_acc && bus_idx == REG_IDX_W'(int'(IDX_NUM_LO) + k))
          num_q[k*BUS_W +: BUS_W] <= bus_wdata;
        if (wr_acc && bus_idx == REG_IDX_W'(int'(IDX_DEN_LO) + k))
          den_q[k*BUS_W +: BUS_W] <= bus_wdata;
      end
      if (cap) begin
        quo_q  <= core_quo;
        err_q  <= core_err;
        busy_q <= 1'b0;
        if (core_rem_we) rem_q <= core_rem;
      end
    end
  end

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[1:0]           = mode_q;
    ctrl_word[CTRL_ERR_BIT]  = err_q;
    ctrl_word[CTRL_BUSY_BIT] = busy_q;
  end

  hdiv_prep #(.BUS_W(BUS_W)) u_prep (
    .num_raw  (num_q),
    .den_raw  (den_q),
    .mode     (mode_q),
    .num_ext  (p_num_ext),
    .num_mag  (p_num_mag),
    .den_mag  (p_den_mag),
    .num_neg  (p_num_neg),
    .den_neg  (p_den_neg),
    .den_zero (p_den_zero),
    .ovf      (p_ovf)
  );

  hdiv_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_q),
    .num_ext  (p_num_ext),
    .num_mag  (p_num_mag),
    .den_mag  (p_den_mag),
    .num_neg  (p_num_neg),
    .den_neg  (p_den_neg),
    .den_zero (p_den_zero),
    .ovf      (p_ovf),
    .done     (core_done),
    .quo      (core_quo),
    .rem      (core_rem),
    .err      (core_err),
    .rem_we   (core_rem_we)
  );

  hdiv_rdmux #(.BUS_W(BUS_W)) u_rdmux (
    .idx       (bus_idx),
    .ctrl_word (ctrl_word),
    .num       (num_q),
    .den       (den_q),
    .quo       (quo_q),
    .rem       (rem_q),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/hdiv_chk.sv
module hdiv_chk #(
  parameter int unsigned BUS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_wr,
  input logic               cap,
  input logic               core_rem_we,
  input logic               busy,
  input logic               err,
  input logic [2*BUS_W-1:0] quo,
  input logic [2*BUS_W-1:0] rem
);
  localparam int unsigned DATA_W  = 2 * BUS_W;
  localparam int unsigned LAT_CHK = DATA_W + 3;
  localparam int unsigned CW      = $clog2(LAT_CHK + 2);

  logic [CW-1:0] since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_wr <= '0;
    else if (op_wr)            since_wr <= CW'(1);
    else if (since_wr != '1)   since_wr <= since_wr + 1'b1;
  end

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |=> busy);  // R2
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> since_wr == CW'(LAT_CHK));  // R10
  AST_CAPTURE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> busy);  // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(quo) && $stable(rem));  // R9
  AST_IDLE_RESULTS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(quo) && $stable(rem));  // R9
  AST_OVERFLOW_KEEPS_REM: assert property (@(posedge clk) disable iff (!rst_n)
    cap && !core_rem_we |=> err && $stable(rem));  // R8
endmodule

bind hdiv_unit hdiv_chk #(.BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_wr       (op_wr),
  .cap         (cap),
  .core_rem_we (core_rem_we),
  .busy        (busy_q),
  .err         (err_q),
  .quo         (quo_q),
  .rem         (rem_q)
);

// File: tb/sim_hdiv_unit.sv
module sim_hdiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 66;   // 2*32+2 cycles of busy
  localparam int NVEC       = 14;

  // {mode, numerator, denominator}
  localparam logic [129:0] VEC [NVEC] = '{
    {2'd0, 64'h0000000000000064, 64'h0000000000000007},
    {2'd0, 64'hDEADBEEFFFFFFF9C, 64'h1234567800000007},
    {2'd3, 64'h8000000000000000, 64'h00000000FFFFFFFF},
    {2'd0, 64'h0000000080000000, 64'h00000000FFFFFFFF},
    {2'd1, 64'h0000000100000000, 64'hABCDEF01FFFFFFFE},
    {2'd2, 64'hFFFFFFFFFFFFFFF9, 64'h0000000000000002},
    {2'd2, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF},
    {2'd2, 64'h0000000000000007, 64'hFFFFFFFFFFFFFFFE},
    {2'd2, 64'h7FFFFFFFFFFFFFFF, 64'h0000000000000003},
    {2'd2, 64'hFFFFFFFFFFFFFF00, 64'h0000000000000000},
    {2'd2, 64'h0000000000000123, 64'h0000000000000000},
    {2'd0, 64'hFFFFFFFF00000005, 64'h0000000100000000},
    {2'd2, 64'h8000000000000000, 64'h0000000000000001},
    {2'd2, 64'h8000000000000000, 64'h8000000000000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_idx = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic        bus_ready;
  logic [31:0] bus_rdata;

  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;
  logic [63:0] model_rem = 64'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_idx = idx;
    #1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rd64(input logic [3:0] lo, output logic [63:0] d);
    logic [31:0] a, b;
    rd(lo, a);
    rd(4'(lo + 4'd1), b);
    d = {b, a};
  endtask

  task automatic start_op(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d);
    wr(4'd1, n[31:0]);
    wr(4'd2, n[63:32]);
    wr(4'd3, d[31:0]);
    wr(4'd4, d[63:32]);
    wr(4'd0, {30'd0, m});
  endtask

  // counts cycles with busy set, starting at the sample after the last write
  task automatic wait_idle(output int n);
    logic [31:0] c;
    n = 0;
    rd(4'd0, c);
    while (c[15] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(4'd0, c);
    end
  endtask

  function automatic logic [63:0] sext(input logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic void model(input logic [1:0] m, input logic [63:0] nr, input logic [63:0] dr,
                                input logic [63:0] prev, output logic [63:0] q,
                                output logic [63:0] r, output logic e);
    longint n, d;
    n = (m == 2'd0) ? longint'(sext(nr)) : longint'(nr);
    d = (m == 2'd2) ? longint'(dr) : longint'(sext(dr));
    if (d == 0) begin
      q = (n < 0) ? 64'd1 : 64'd0; r = n; e = 1'b1;
    end else if (n == longint'(64'h8000000000000000) && d == -1) begin
      q = n; r = prev; e = 1'b1;
    end else begin
      q = n / d; r = n % d; e = 1'b0;
    end
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [63:0] nr, input logic [63:0] dr);
    logic [63:0] n, d;
    string mt;
    n = (m == 2'd0) ? sext(nr) : nr;
    d = (m == 2'd2) ? dr : sext(dr);
    mt = (m == 2'd0) ? "R3" : (m == 2'd2) ? "R5" : "R4";
    if (d == 64'd0) return {"R7/", mt};
    if (n == 64'h8000000000000000 && d == '1) return {"R8/", mt};
    return {"R6/", mt};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [63:0] v, eq, er, qa, ra;
    logic        ee;
    int          lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(4'd0, w);       check("R1", "ctrl after reset", {32'd0, w}, 64'd0);
    rd64(4'd1, v);     check("R1", "numerator after reset", v, 64'd0);
    rd64(4'd3, v);     check("R1", "denominator after reset", v, 64'd0);
    rd64(4'd5, v);     check("R1", "quotient after reset", v, 64'd0);
    rd64(4'd7, v);     check("R1", "remainder after reset", v, 64'd0);
    // R11: always ready
    check("R11", "bus_ready", {63'd0, bus_ready}, 64'd1);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  m;
      logic [63:0] n, d;
      string       tg;
      m = VEC[i][129:128];
      n = VEC[i][127:64];
      d = VEC[i][63:0];
      tg = tag_of(m, n, d);
      model(m, n, d, model_rem, eq, er, ee);
      start_op(m, n, d);
      wait_idle(lat);
      check("R2", $sformatf("vec %0d latency", i), 64'(lat), 64'(LAT));
      rd64(4'd5, v);  check(tg, $sformatf("vec %0d quotient", i), v, eq);
      rd64(4'd7, v);  check(tg, $sformatf("vec %0d remainder", i), v, er);
      rd(4'd0, w);
      check(tg, $sformatf("vec %0d error bit14", i), {63'd0, w[14]}, {63'd0, ee});
      check("R1", $sformatf("vec %0d mode readback", i), {62'd0, w[1:0]}, {62'd0, m});
      model_rem = er;
    end

    // R9: previous results visible while busy; result-index writes ignored
    rd64(4'd5, qa);
    rd64(4'd7, ra);
    start_op(2'd2, 64'd1000, 64'd3);
    repeat (5) @(negedge clk);
    rd64(4'd5, v);  check("R9", "quotient held while busy", v, qa);
    rd64(4'd7, v);  check("R9", "remainder held while busy", v, ra);
    wait_idle(lat);
    rd64(4'd5, v);  check("R6", "1000/3 quotient", v, 64'd333);
    rd64(4'd7, v);  check("R6", "1000/3 remainder", v, 64'd1);
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd8, 32'h1234_5678);
    rd(4'd0, w);    check("R9", "busy after result-index write", {63'd0, w[15]}, 64'd0);
    rd64(4'd5, v);  check("R9", "quotient after ignored write", v, 64'd333);
    rd64(4'd7, v);  check("R9", "remainder after ignored write", v, 64'd1);

    // R10: restart in mid-computation
    start_op(2'd2, 64'd1000, 64'd10);
    repeat (10) @(negedge clk);
    wr(4'd3, 32'd7);
    wait_idle(lat);
    check("R10", "latency from restart", 64'(lat), 64'(LAT));
    rd64(4'd5, v);  check("R10", "quotient after restart", v, 64'd142);
    rd64(4'd7, v);  check("R10", "remainder after restart", v, 64'd6);

    // R10: control-only write restarts with the new mode
    wr(4'd2, 32'hFFFF_FFFF);      // numerator high word now all ones
    wr(4'd0, 32'd0);               // mode 0 ignores it
    wait_idle(lat);
    check("R10", "latency from control write", 64'(lat), 64'(LAT));
    rd64(4'd5, v);  check("R3", "mode 0 ignores numerator high word", v, 64'd142);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule